// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Per-Pin Interrupt Styles

This block is a general-purpose I/O port for sixteen pins. It sits on a plain 32-bit register bus that carries only whole-word reads and writes. Software sets the driven value and the drive enable of each pin, and reads back the pin levels after they have passed through a synchroniser. The pads are outside the block: each pin appears as an input bit, an output bit and an output-enable bit.

Every pin has its own interrupt detector, programmed with a 3-bit style code. The detector reacts either to a level, high or low, or to a change of the synchronised level, which can be a rise, a fall or either. Detected events collect in a sticky status word, which software clears by writing ones. Any set status bit raises one shared interrupt line.

Top module: `gpio_port`

## Requirements
- R1: A write to byte offset 0x00 loads the pin output value and a write to 0x04 loads the output-enable vector. Bit n of each drives `pin_out[n]` / `pin_oe[n]` from the next cycle. Both read back in bits [15:0], with bits [31:16] reading 0.
- R2: A read of offset 0x08 returns the pin levels after a two-flop synchroniser. A pin change driven before clock edge k is visible to a read sampled at edge k+2 but not to one sampled at edge k+1. Writes to 0x08 change nothing.
- R3: The style of pin n is the 3-bit field at bits [3*(n mod 8)+2 : 3*(n mod 8)]. For pins 0–7 the field is in the register at 0x10, and for pins 8–15 it is in the register at 0x14. Both registers read back bits [23:0], and bits [31:24] read 0.
- R4: Style code 0 sets the pin's status bit on every cycle in which the synchronised level is 1. Style code 1 does the same when the level is 0.
- R5: An edge is found by comparing the synchronised level with its value one cycle earlier. Style code 2 detects a 0→1 change, code 3 a 1→0 change and code 4 either change. Each detection sets the status bit once.
- R6: Style codes 5, 6 and 7 never set a status bit.
- R7: The status word at offset 0x0C has one bit per pin, bit n for pin n. Bits are sticky until a write with a 1 in the bit position clears them. The clear takes effect in the write cycle itself, and a level condition that is still present sets the bit again one cycle later. An edge detected in the same cycle as a clear leaves the bit set.
- R8: `irq` is 1 exactly when at least one status bit is 1.
- R9: After reset, `pin_out`, `pin_oe`, all style fields, the status word and `irq` are 0.
- R10: `bus_rdata` is registered and loads on the clock edge that samples a read request. It holds its value when no read is requested. A read of any offset other than the six mapped words returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus request valid for this cycle |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 6 | Byte offset of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after the read request |
| pin_in | input | 16 | Levels received from the pads (asynchronous) |
| pin_out | output | 16 | Values to drive onto the pads |
| pin_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an edge detection that lands in exactly the same cycle as a write-one-to-clear of the status word. The clear must remove the bits it names but must not remove the new edge. To hit that cycle, the bench counts the synchroniser and detector stages from the pin change and issues the clear write so that it is sampled on the third edge after the change. It also clears a second, previously set bit in the same write, then reads the word back. Level re-assertion after a clear is caught by reading in the cycle right after the clear, which must show zero, and again one cycle later, which must show the bit back. This is done for every pin under every style code.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  localparam int STYLE_W       = 3;
  localparam int PINS_PER_TREG = 8;
  localparam int TREG_BITS     = STYLE_W * PINS_PER_TREG;

  typedef logic [STYLE_W-1:0] style_t;

  localparam style_t STY_HIGH = 3'd0;
  localparam style_t STY_LOW  = 3'd1;
  localparam style_t STY_RISE = 3'd2;
  localparam style_t STY_FALL = 3'd3;
  localparam style_t STY_ANY  = 3'd4;

  localparam logic [5:0] OFS_DOUT = 6'h00;
  localparam logic [5:0] OFS_DOE  = 6'h04;
  localparam logic [5:0] OFS_DIN  = 6'h08;
  localparam logic [5:0] OFS_STAT = 6'h0C;
  localparam logic [5:0] OFS_TYP0 = 6'h10;
  localparam logic [5:0] OFS_TYP1 = 6'h14;

endpackage

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] lvl_d
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl   = lvl_q;
  assign lvl_d = prev_q;

endmodule

// File: rtl/gpio_port_detect.sv
`timescale 1ns/1ps
module gpio_port_detect
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0]         lvl,
  input  logic [NPINS-1:0]         lvl_d,
  input  logic [NPINS*STYLE_W-1:0] styles,
  output logic [NPINS-1:0]         lvl_evt,
  output logic [NPINS-1:0]         edg_evt
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    style_t sty;
    logic   l_e;
    logic   e_e;

    assign sty = styles[i*STYLE_W +: STYLE_W];

    always_comb begin
      l_e = 1'b0;
      e_e = 1'b0;
      case (sty)
        STY_HIGH: l_e = lvl[i];
        STY_LOW:  l_e = ~lvl[i];
        STY_RISE: e_e = lvl[i] & ~lvl_d[i];
        STY_FALL: e_e = ~lvl[i] & lvl_d[i];
        STY_ANY:  e_e = lvl[i] ^ lvl_d[i];
        default:  begin l_e = 1'b0; e_e = 1'b0; end
      endcase
    end

    assign lvl_evt[i] = l_e;
    assign edg_evt[i] = e_e;
  end

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [NPINS-1:0]         pin_lvl,
  input  logic [NPINS-1:0]         lvl_evt,
  input  logic [NPINS-1:0]         edg_evt,
  output logic [NPINS-1:0]         dout,
  output logic [NPINS-1:0]         doe,
  output logic [NPINS-1:0]         status,
  output logic [NPINS*STYLE_W-1:0] styles
);

  localparam int PADW = DW - NPINS;
  localparam int TPAD = DW - TREG_BITS;

  logic wr, rd;
  logic hit_dout, hit_doe, hit_din, hit_stat, hit_typ0, hit_typ1;
  logic dout_en, doe_en, typ0_en, typ1_en, rd_en;

  logic [NPINS-1:0]     dout_q, dout_d;
  logic [NPINS-1:0]     doe_q, doe_d;
  logic [NPINS-1:0]     stat_q, stat_d;
  logic [NPINS-1:0]     clr;
  logic [TREG_BITS-1:0] typ0_q, typ0_d, typ1_q, typ1_d;
  logic [DW-1:0]        rdata_q, rdata_d;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:TREG_BITS];

  assign wr = bus_sel &  bus_write;
  assign rd = bus_sel & ~bus_write;

  assign hit_dout = (bus_addr == AW'(OFS_DOUT));
  assign hit_doe  = (bus_addr == AW'(OFS_DOE));
  assign hit_din  = (bus_addr == AW'(OFS_DIN));
  assign hit_stat = (bus_addr == AW'(OFS_STAT));
  assign hit_typ0 = (bus_addr == AW'(OFS_TYP0));
  assign hit_typ1 = (bus_addr == AW'(OFS_TYP1));

  assign dout_en = wr & hit_dout;
  assign doe_en  = wr & hit_doe;
  assign typ0_en = wr & hit_typ0;
  assign typ1_en = wr & hit_typ1;
  assign rd_en   = rd;

  // next-state logic
  always_comb begin
    dout_d = bus_wdata[NPINS-1:0];
    doe_d  = bus_wdata[NPINS-1:0];
    typ0_d = bus_wdata[TREG_BITS-1:0];
    typ1_d = bus_wdata[TREG_BITS-1:0];
    clr    = (wr & hit_stat) ? bus_wdata[NPINS-1:0] : '0;
    // clear beats a level condition this cycle; an edge always lands
    stat_d = (stat_q & ~clr) | edg_evt | (lvl_evt & ~clr);

    rdata_d = '0;
    if (hit_dout)      rdata_d = {{PADW{1'b0}}, dout_q};
    else if (hit_doe)  rdata_d = {{PADW{1'b0}}, doe_q};
    else if (hit_din)  rdata_d = {{PADW{1'b0}}, pin_lvl};
    else if (hit_stat) rdata_d = {{PADW{1'b0}}, stat_q};
    else if (hit_typ0) rdata_d = {{TPAD{1'b0}}, typ0_q};
    else if (hit_typ1) rdata_d = {{TPAD{1'b0}}, typ1_q};
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      doe_q   <= '0;
      typ0_q  <= '0;
      typ1_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (dout_en) dout_q  <= dout_d;
      if (doe_en)  doe_q   <= doe_d;
      if (typ0_en) typ0_q  <= typ0_d;
      if (typ1_en) typ1_q  <= typ1_d;
      if (rd_en)   rdata_q <= rdata_d;
      stat_q <= stat_d;
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_sty
    if (n < PINS_PER_TREG) begin : g_lo
      assign styles[n*STYLE_W +: STYLE_W] = typ0_q[n*STYLE_W +: STYLE_W];
    end else begin : g_hi
      assign styles[n*STYLE_W +: STYLE_W] =
        typ1_q[(n-PINS_PER_TREG)*STYLE_W +: STYLE_W];
    end
  end

  assign dout      = dout_q;
  assign doe       = doe_q;
  assign status    = stat_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  logic                     rst_s1_q, rst_s2_q;
  logic                     rst_int_n;
  logic [NPINS-1:0]         lvl, lvl_d, lvl_evt, edg_evt, status;
  logic [NPINS*STYLE_W-1:0] styles;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  gpio_port_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_in (pin_in),
    .lvl    (lvl),
    .lvl_d  (lvl_d)
  );

  gpio_port_detect #(.NPINS(NPINS)) u_detect (
    .lvl     (lvl),
    .lvl_d   (lvl_d),
    .styles  (styles),
    .lvl_evt (lvl_evt),
    .edg_evt (edg_evt)
  );

  gpio_port_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl   (lvl),
    .lvl_evt   (lvl_evt),
    .edg_evt   (edg_evt),
    .dout      (pin_out),
    .doe       (pin_oe),
    .status    (status),
    .styles    (styles)
  );

  assign irq = |status;

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq
);

  logic rd_req, wr_req;
  assign rd_req = bus_sel & ~bus_write;
  assign wr_req = bus_sel &  bus_write;

  assert_dout_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == AW'(OFS_DOUT)) |=> (pin_out == $past(wdata)));

  assert_din_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == AW'(OFS_DIN)) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_type_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (bus_addr == AW'(OFS_TYP0) || bus_addr == AW'(OFS_TYP1)))
      |=> (bus_rdata[DW-1:TREG_BITS] == '0));

  assert_irq_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_req && bus_addr == AW'(OFS_STAT)));

  assert_irq_matches_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == AW'(OFS_STAT)) |=> ((bus_rdata != '0) == $past(irq)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wdata     (bus_wdata[NPINS-1:0]),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] all_styles(input logic [2:0] s);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w |= 32'(s) << (3*k);
    return w;
  endfunction

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic [15:0] bit_n, exp16;
    logic [31:0] t0, t1;

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state
    check("R9 pin_out", {16'h0, pin_out}, 32'h0);
    check("R9 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R9 irq", {31'h0, irq}, 32'h0);
    rd(6'h10, r); check("R9 type0", r, 32'h0);
    rd(6'h14, r); check("R9 type1", r, 32'h0);
    rd(6'h0C, r); check("R9 status", r, 32'h0);
    rd(6'h00, r); check("R9 dout", r, 32'h0);

    // R1 output data and enable, walking ones and all ones
    for (int i = 0; i <= 16; i++) begin
      logic [31:0] v = (i == 16) ? 32'hFFFF_FFFF : (32'h1 << i);
      wr(6'h00, v);
      check("R1 pin_out", {16'h0, pin_out}, v & 32'hFFFF);
      rd(6'h00, r); check("R1 dout readback", r, v & 32'hFFFF);
      wr(6'h04, ~v);
      check("R1 pin_oe", {16'h0, pin_oe}, ~v & 32'hFFFF);
      rd(6'h04, r); check("R1 doe readback", r, ~v & 32'hFFFF);
    end
    wr(6'h00, 32'h0000_5A3C);
    wr(6'h04, 32'h0000_C3A5);

    // R2 synchroniser latency and read-only input word
    pin_in = 16'h1234;
    idle(4);
    pin_in = 16'hBEEF;
    rd(6'h08, r); check("R2 latency edge1", r, 32'h1234);
    rd(6'h08, r); check("R2 latency edge2", r, 32'h1234);
    rd(6'h08, r); check("R2 latency edge3", r, 32'hBEEF);
    wr(6'h08, 32'hFFFF_0000);
    rd(6'h08, r); check("R2 write ignored", r, 32'hBEEF);
    check("R2 pin_out kept", {16'h0, pin_out}, 32'h5A3C);
    check("R2 pin_oe kept", {16'h0, pin_oe}, 32'hC3A5);

    // R3 type register width
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, r); check("R3 type0 mask", r, 32'h00FF_FFFF);
    wr(6'h14, 32'h1234_5678); rd(6'h14, r); check("R3 type1 mask", r, 32'h0034_5678);

    // R10 unmapped reads and hold
    rd(6'h18, r); check("R10 unmapped 0x18", r, 32'h0);
    rd(6'h3C, r); check("R10 unmapped 0x3C", r, 32'h0);
    rd(6'h14, r); idle(3); check("R10 hold", bus_rdata, 32'h0034_5678);

    // R3..R8 sweep: every pin, every style code
    for (int n = 0; n < NP; n++) begin
      for (int s = 0; s < 8; s++) begin
        bit_n = 16'h1 << n;
        t0 = 32'h00FF_FFFF; t1 = 32'h00FF_FFFF;
        if (n < 8) t0 = (t0 & ~(32'h7 << (3*n))) | (32'(s) << (3*n));
        else       t1 = (t1 & ~(32'h7 << (3*(n-8)))) | (32'(s) << (3*(n-8)));
        pin_in = '0;
        wr(6'h10, t0); wr(6'h14, t1);
        idle(4);
        wr(6'h0C, 32'hFFFF); idle(1);
        rd(6'h0C, r); check("R4 low level idle", r, (s == 1) ? 32'(bit_n) : 32'h0);

        pin_in = bit_n; idle(4);
        exp16 = (s == 0 || s == 1 || s == 2 || s == 4 || (s==1)) ? bit_n : 16'h0;
        rd(6'h0C, r); check("R5 R6 after rise", r, 32'(exp16));
        check("R8 irq after rise", {31'h0, irq}, {31'h0, exp16 != 0});

        wr(6'h0C, 32'hFFFF);
        rd(6'h0C, r); check("R7 clear wins", r, 32'h0);
        rd(6'h0C, r); check("R7 level re-sets", r, (s == 0) ? 32'(bit_n) : 32'h0);

        pin_in = '0; idle(4);
        exp16 = (s == 0 || s == 1 || s == 3 || s == 4) ? bit_n : 16'h0;
        rd(6'h0C, r); check("R5 R6 after fall", r, 32'(exp16));
        check("R8 irq after fall", {31'h0, irq}, {31'h0, exp16 != 0});

        wr(6'h0C, 32'hFFFF);
        rd(6'h0C, r); check("R7 clear wins low", r, 32'h0);
        rd(6'h0C, r); check("R4 low re-sets", r, (s == 1) ? 32'(bit_n) : 32'h0);
      end
    end

    // R5 all pins at once
    pin_in = '0;
    wr(6'h10, all_styles(3'd2)); wr(6'h14, all_styles(3'd2));
    idle(4); wr(6'h0C, 32'hFFFF); idle(1);
    pin_in = 16'hA5C3; idle(4);
    rd(6'h0C, r); check("R5 multi rise", r, 32'h0000_A5C3);
    wr(6'h10, all_styles(3'd3)); wr(6'h14, all_styles(3'd3));
    wr(6'h0C, 32'hFFFF); idle(1);
    pin_in = 16'h0F0F; idle(4);
    rd(6'h0C, r); check("R5 multi fall", r, 32'(16'hA5C3 & ~16'h0F0F));
    wr(6'h10, all_styles(3'd4)); wr(6'h14, all_styles(3'd4));
    wr(6'h0C, 32'hFFFF); idle(1);
    pin_in = 16'hFFFF; idle(4);
    rd(6'h0C, r); check("R5 multi any", r, 32'(16'h0F0F ^ 16'hFFFF));

    // R7 edge arriving in the same cycle as a clear survives it
    wr(6'h10, all_styles(3'd2)); wr(6'h14, all_styles(3'd2));
    pin_in = '0; idle(4); wr(6'h0C, 32'hFFFF); idle(1);
    pin_in = 16'h0002; idle(4);
    rd(6'h0C, r2); check("R7 pin1 set", r2, 32'h2);
    pin_in = 16'h0003;
    idle(2);
    wr(6'h0C, 32'h3);
    rd(6'h0C, r); check("R7 edge beats clear", r, 32'h1);
    check("R8 irq stays", {31'h0, irq}, 32'h1);
    wr(6'h0C, 32'h1); idle(1);
    check("R8 irq drops", {31'h0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule